// File: doc/BRIEF.md
# Retimed Split-Product Multiplier Stage

This block is one stage of an unsigned 16 x 16 multiplier pipeline. The delay is moved across the register boundary so that neither side of the register holds a full-width multiply. The second operand is cut into an upper byte and a lower byte. Each byte is multiplied by the whole first operand, and the two 24-bit partial products are registered. After the register, a single adder recombines them into the 32-bit product.

The stage has no operand registers of its own. Its multipliers take the next-state operand values, meaning the values that the upstream registers would have loaded on the coming edge. Those upstream registers are therefore absorbed, and the multiply logic starts one stage earlier. The outside view is unchanged: the product of the operands presented at an edge appears during the cycle after that edge. A valid flag travels alongside the partial-product registers and marks which cycles carry a real product.

The operand width and the cut position are parameters. The default is 16-bit operands cut at bit 8.

Top module: `retimed_split_mult`

## Requirements
- R1: While reset is held through an edge, the output `product` reads 0 and `out_valid` reads 0 during the following cycle.
- R2: For any operands `opa_next` and `opb_next` present at a rising edge with reset low, `product` during the following cycle equals their unsigned 32-bit product.
- R3: `out_valid` during a cycle equals the value of `in_valid` at the preceding rising edge, when reset was low at that edge.
- R4: The partial products are captured on every edge regardless of `in_valid`, so `product` follows R2 even when `in_valid` is 0.
- R5: The recombination adds the upper-byte partial product shifted left by 8 bits to the zero-extended lower-byte partial product. Carries from that overlap reach bit 31: 0xFFFF x 0xFFFF gives 0xFFFE0001.
- R6: A synchronous reset asserted in the middle of a run overrides `in_valid=1` and nonzero operands. The next cycle shows `product` = 0 and `out_valid` = 0, and normal products resume on the first edge after reset is released.
- R7: Operands that exercise only one partial product give exact results: 0x8000 x 0x8000 gives 0x40000000; 0x0001 x 0xFF00 gives 0x0000FF00; 0x1234 x 0x00FF gives 0x001221CC; and any operand times 0 gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opa_next | input | 16 | Next-state value of the first operand (upstream register D input) |
| opb_next | input | 16 | Next-state value of the second operand, cut at bit 8 |
| in_valid | input | 1 | Marks the operands at this edge as a real request |
| product | output | 32 | Unsigned product of the operands from the previous edge |
| out_valid | output | 1 | Valid flag delayed by one cycle |

## Verification
A partial-product register that captures the wrong byte, a wrong slice width or a wrong alignment in the adder shows up at `product` in the very next cycle. An operand pair that loads only the affected slice exposes it in isolation. Single-byte operands and 0x8000 separate the two slices, and 0xFFFF x 0xFFFF exposes a carry dropped in the overlap of the two partials. A valid register that is skipped, doubled or gated by reset incorrectly is seen on `out_valid` one cycle after the input flag or the reset changes.

// File: rtl/retimed_split_mult_pkg.sv
package retimed_split_mult_pkg;
  // Widths of the two partial products for a given operand width and cut point.
  function automatic int hi_part_w(input int op_w, input int cut);
    return op_w + (op_w - cut);
  endfunction

  function automatic int lo_part_w(input int op_w, input int cut);
    return op_w + cut;
  endfunction
endpackage

// File: rtl/rsm_slice_mult.sv
// One registered partial product: full first operand times one slice of the second.
module rsm_slice_mult #(
  parameter int A_W = 16,
  parameter int B_W = 8,
  localparam int P_W = A_W + B_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [A_W-1:0] a_next,
  input  logic [B_W-1:0] b_slice_next,
  output logic [P_W-1:0] part_q
);
  logic [P_W-1:0] part_d;

  always_comb begin
    part_d = {{B_W{1'b0}}, a_next} * {{A_W{1'b0}}, b_slice_next};
  end

  // Captured every edge; validity is tracked separately by the top.
  always_ff @(posedge clk) begin
    if (rst) part_q <= '0;
    else     part_q <= part_d;
  end

  // R1 / R6: a reset edge leaves the partial register cleared.
  assert_slice_cleared_R6: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> part_q == '0);
endmodule

// File: rtl/rsm_recombine.sv
// Combinational recombination after the register boundary.
module rsm_recombine #(
  parameter int OP_W = 16,
  parameter int CUT  = 8,
  localparam int HI_W = retimed_split_mult_pkg::hi_part_w(OP_W, CUT),
  localparam int LO_W = retimed_split_mult_pkg::lo_part_w(OP_W, CUT),
  localparam int PR_W = 2 * OP_W
) (
  input  logic [HI_W-1:0] hi_part,
  input  logic [LO_W-1:0] lo_part,
  output logic [PR_W-1:0] sum
);
  logic [PR_W-1:0] hi_aligned;
  logic [PR_W-1:0] lo_aligned;

  always_comb begin
    hi_aligned = {hi_part, {CUT{1'b0}}};
    lo_aligned = {{(OP_W - CUT){1'b0}}, lo_part};
    sum        = hi_aligned + lo_aligned;
  end
endmodule

// File: rtl/retimed_split_mult.sv
module retimed_split_mult #(
  parameter int OP_W = 16,
  parameter int CUT  = 8,
  localparam int HI_B = OP_W - CUT,
  localparam int HI_W = retimed_split_mult_pkg::hi_part_w(OP_W, CUT),
  localparam int LO_W = retimed_split_mult_pkg::lo_part_w(OP_W, CUT),
  localparam int PR_W = 2 * OP_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opa_next,
  input  logic [OP_W-1:0] opb_next,
  input  logic            in_valid,
  output logic [PR_W-1:0] product,
  output logic            out_valid
);
  logic [HI_W-1:0] hi_q;
  logic [LO_W-1:0] lo_q;
  logic            vld_q;

  // Upper slice of the second operand.
  rsm_slice_mult #(.A_W(OP_W), .B_W(HI_B)) u_hi (
    .clk(clk), .rst(rst),
    .a_next(opa_next), .b_slice_next(opb_next[OP_W-1:CUT]),
    .part_q(hi_q)
  );

  // Lower slice of the second operand.
  rsm_slice_mult #(.A_W(OP_W), .B_W(CUT)) u_lo (
    .clk(clk), .rst(rst),
    .a_next(opa_next), .b_slice_next(opb_next[CUT-1:0]),
    .part_q(lo_q)
  );

  rsm_recombine #(.OP_W(OP_W), .CUT(CUT)) u_sum (
    .hi_part(hi_q), .lo_part(lo_q), .sum(product)
  );

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= in_valid;
  end
  assign out_valid = vld_q;

  // R3: valid has exactly one cycle of latency.
  assert_valid_latency_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> out_valid == $past(in_valid));

  // R2: product matches the full multiply of last edge's operands.
  assert_product_exact_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> product ==
      ({{OP_W{1'b0}}, $past(opa_next)} * {{OP_W{1'b0}}, $past(opb_next)}));

  // R1: reset clears the valid flag.
  assert_reset_clears_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid && product == '0);

  // R7: a zero operand gives a zero product.
  assert_zero_operand_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(opa_next) == '0 || $past(opb_next) == '0)) |-> product == '0);
endmodule

// File: tb/retimed_split_mult_tb_top.sv
module retimed_split_mult_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [15:0] opa_next;
  logic [15:0] opb_next;
  logic        in_valid;
  logic [31:0] product;
  logic        out_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  retimed_split_mult dut_i (
    .clk(clk), .rst(rst), .opa_next(opa_next), .opb_next(opb_next),
    .in_valid(in_valid), .product(product), .out_valid(out_valid)
  );

  task automatic check(input string req, input logic [31:0] act_p, input logic [31:0] exp_p,
                       input logic act_v, input logic exp_v);
    n_checks++;
    if (act_p !== exp_p || act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: product=%h valid=%b expected product=%h valid=%b",
               req, act_p, act_v, exp_p, exp_v);
    end
  endtask

  // Drive at a falling edge, let one rising edge pass, sample at the next falling edge.
  task automatic apply(input string req, input logic [15:0] a, input logic [15:0] b,
                       input logic v);
    logic [31:0] exp_p;
    opa_next = a; opb_next = b; in_valid = v;
    exp_p = {16'b0, a} * {16'b0, b};
    @(negedge clk);
    check(req, product, exp_p, out_valid, v);
  endtask

  task automatic t_reset();
    rst = 1'b1; opa_next = 16'hABCD; opb_next = 16'h1234; in_valid = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1", product, 32'h0, out_valid, 1'b0);
    rst = 1'b0;
  endtask

  task automatic t_corners();
    apply("R5", 16'hFFFF, 16'hFFFF, 1'b1);
    apply("R7", 16'h8000, 16'h8000, 1'b1);
    apply("R7", 16'h0001, 16'hFF00, 1'b1);
    apply("R7", 16'h1234, 16'h00FF, 1'b1);
    apply("R7", 16'h0000, 16'hFFFF, 1'b1);
    apply("R7", 16'hFFFF, 16'h0000, 1'b1);
    apply("R5", 16'hFFFF, 16'h0100, 1'b1);
    apply("R5", 16'h00FF, 16'hFFFF, 1'b1);
  endtask

  task automatic t_valid_pattern();
    apply("R3", 16'h0003, 16'h0005, 1'b0);
    apply("R4", 16'h7FFF, 16'h8001, 1'b0);
    apply("R3", 16'h0101, 16'h0101, 1'b1);
    apply("R4", 16'hC3A5, 16'h5A3C, 1'b0);
    apply("R3", 16'h0002, 16'h0002, 1'b1);
  endtask

  task automatic t_random();
    for (int i = 0; i < 300; i++) begin
      apply("R2", 16'($urandom), 16'($urandom), 1'($urandom));
    end
  endtask

  task automatic t_mid_reset();
    apply("R2", 16'h4321, 16'h8765, 1'b1);
    rst = 1'b1; opa_next = 16'hFFFF; opb_next = 16'hFFFF; in_valid = 1'b1;
    @(negedge clk);
    check("R6", product, 32'h0, out_valid, 1'b0);
    rst = 1'b0;
    apply("R6", 16'h1111, 16'h2222, 1'b1);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_corners();
    t_valid_pattern();
    t_random();
    t_mid_reset();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    finish_run();
  end
endmodule